// File: doc/BRIEF.md
# Coprocessor Function Request Switch

This switch sits between a set of RISC processing cores and a pool of shared coprocessors. Each core offers one request at a time: an instruction word, the number of the task that issued it and that task's priority. The top four bits of the instruction word give the instruction group. Group 0 belongs to the cores themselves. Each group from 1 up to the configured type count names one coprocessor type, and every type has the same number of identical units.

For every type, the switch gathers the pending requests and the free units. Whenever at least one unit of that type is ready, it passes one request to one unit. The request with the highest priority wins. Among requests of equal priority, a per-type rotating pointer shares the grants out in turn. The instruction word and the task number reach the unit unchanged, because the lower opcode bits mean something only to the coprocessor type. A request whose group is 0, or is above the configured type count, is taken off its core and flagged as a routing error. It is never forwarded.

Back-pressure rules. On the core side, a request is complete in any cycle in which `req_valid` and `req_ready` are both high. The core must hold its request stable until that cycle. On the unit side, `cop_ready` means the unit can take work in that cycle. `cop_valid` is raised only toward a unit whose `cop_ready` is high, and the transfer completes in that same cycle. Both handshakes are decided combinationally, in the cycle in which they complete.

Top module: `cop_req_switch`

## Requirements
- R1: Bits [IW-1:IW-4] of the instruction form the group g. A request with 1 <= g <= NT goes to a unit of type g-1, that is, to one of units (g-1)*UPT .. (g-1)*UPT+UPT-1. The unit receives the full instruction word and the task number unchanged.
- R2: A valid request with g = 0 or g > NT raises `req_err` and `req_ready` for that core in the same cycle and reaches no unit.
- R3: Among contending requests for one type, the one with the numerically largest priority value wins.
- R4: Among requests of equal top priority, the grant goes to the first requesting core after the core last granted for that type, in ascending circular order. After reset, core 0 comes first in this order.
- R5: A type's rotation pointer moves only in a cycle in which that type completes a transfer.
- R6: A winning request goes to the lowest-index ready unit of its type. While no unit of the type is ready, no request for that type gets `req_ready`.
- R7: A request waiting on a type that has no ready unit never holds back requests for other types.
- R8: Each type completes at most one transfer per cycle, and `cop_valid` is high only toward a unit whose `cop_ready` is high.
- R9: While `rst_n` is low, all of `req_ready`, `req_err` and `cop_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NC | Per-core request valid |
| req_instr | input | NC*IW | Per-core instruction words, core c at [c*IW +: IW] |
| req_task | input | NC*TW | Per-core task numbers |
| req_prio | input | NC*PW | Per-core task priorities, larger is more urgent |
| req_ready | output | NC | Request taken (granted or discarded as an error) |
| req_err | output | NC | Request has an illegal group and was discarded |
| cop_valid | output | NT*UPT | Per-unit request valid, unit u has type u/UPT |
| cop_instr | output | NT*UPT*IW | Per-unit forwarded instruction word |
| cop_task | output | NT*UPT*TW | Per-unit forwarded task number |
| cop_ready | input | NT*UPT | Per-unit ready to accept |

## Verification
The bound assertions check, on every cycle, that each transfer goes to a unit whose group code matches and that is ready, that each type moves at most one request, that error flags always retire their request, and that every core grant is matched by exactly one unit transfer. Which request wins a contended type is a matter of history, because it depends on the rotation pointer and on the priorities. Only the bench's scenarios can show this, so the bench compares against a model of priorities and pointers over long mixed sweeps and short directed sequences. The same holds for non-blocking across types and for the pointer staying put when nothing is transferred.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int GRP_W = 4;
endpackage

// File: rtl/cfs_decode.sv
module cfs_decode
  import cfs_pkg::*;
#(
  parameter int IW = 32,
  parameter int NT = 15
) (
  input  logic [IW-1:0] instr,
  output logic          legal,
  output logic [NT-1:0] type_hot
);
  logic [GRP_W-1:0] grp;
  assign grp = instr[IW-1 -: GRP_W];

  always_comb begin
    type_hot = '0;
    legal    = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (int'(grp) == t + 1) begin
        type_hot[t] = 1'b1;
        legal       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfs_type_arb.sv
module cfs_type_arb #(
  parameter int NC = 4,
  parameter int PW = 3,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NC-1:0]  req,
  input  logic [NC*PW-1:0] prio,
  input  logic           advance,
  output logic           gnt_any,
  output logic [CW-1:0]  gnt_idx
);
  logic [CW-1:0] last_q;
  logic [PW-1:0] top_p;

  always_comb begin
    top_p = '0;
    for (int c = 0; c < NC; c++)
      if (req[c] && prio[c*PW +: PW] > top_p) top_p = prio[c*PW +: PW];
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = 1; i <= NC; i++) begin
      int j;
      j = (int'(last_q) + i) % NC;
      if (!gnt_any && req[j] && prio[j*PW +: PW] == top_p) begin
        gnt_any = 1'b1;
        gnt_idx = CW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= CW'(NC - 1);
    else if (advance) last_q <= gnt_idx;
  end
endmodule

// File: rtl/cfs_unit_pick.sv
module cfs_unit_pick #(
  parameter int UPT = 2
) (
  input  logic [UPT-1:0] ready,
  output logic           any,
  output logic [UPT-1:0] sel_hot
);
  assign any     = |ready;
  assign sel_hot = ready & (~ready + UPT'(1));
endmodule

// File: rtl/cop_req_switch.sv
module cop_req_switch #(
  parameter int NC  = 4,
  parameter int NT  = 15,
  parameter int UPT = 2,
  parameter int IW  = 32,
  parameter int TW  = 6,
  parameter int PW  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NC-1:0]        req_valid,
  input  logic [NC*IW-1:0]     req_instr,
  input  logic [NC*TW-1:0]     req_task,
  input  logic [NC*PW-1:0]     req_prio,
  output logic [NC-1:0]        req_ready,
  output logic [NC-1:0]        req_err,
  output logic [NT*UPT-1:0]    cop_valid,
  output logic [NT*UPT*IW-1:0] cop_instr,
  output logic [NT*UPT*TW-1:0] cop_task,
  input  logic [NT*UPT-1:0]    cop_ready
);
  localparam int CW = (NC > 1) ? $clog2(NC) : 1;

  logic [NT-1:0] hot   [NC];
  logic [NC-1:0] legal;
  logic [NC-1:0] gvec  [NT];

  for (genvar c = 0; c < NC; c++) begin : g_core
    cfs_decode #(.IW(IW), .NT(NT)) i_dec (
      .instr    (req_instr[c*IW +: IW]),
      .legal    (legal[c]),
      .type_hot (hot[c])
    );
  end

  assign req_err = req_valid & ~legal & {NC{rst_n}};

  for (genvar t = 0; t < NT; t++) begin : g_type
    logic [NC-1:0]  treq;
    logic           gnt_any, unit_any, fire;
    logic [CW-1:0]  gnt_idx;
    logic [UPT-1:0] sel_hot;

    always_comb
      for (int c = 0; c < NC; c++) treq[c] = req_valid[c] & hot[c][t];

    cfs_type_arb #(.NC(NC), .PW(PW)) i_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (treq),
      .prio    (req_prio),
      .advance (fire),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
    );

    cfs_unit_pick #(.UPT(UPT)) i_pick (
      .ready   (cop_ready[t*UPT +: UPT]),
      .any     (unit_any),
      .sel_hot (sel_hot)
    );

    assign fire = gnt_any & unit_any & rst_n;
    assign cop_valid[t*UPT +: UPT] = fire ? sel_hot : '0;

    always_comb begin
      gvec[t] = '0;
      if (fire) gvec[t][gnt_idx] = 1'b1;
    end

    for (genvar k = 0; k < UPT; k++) begin : g_unit
      assign cop_instr[(t*UPT+k)*IW +: IW] = req_instr[gnt_idx*IW +: IW];
      assign cop_task[(t*UPT+k)*TW +: TW]  = req_task[gnt_idx*TW +: TW];
    end
  end

  always_comb begin
    req_ready = req_err;
    for (int t = 0; t < NT; t++) req_ready = req_ready | gvec[t];
  end
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int NC  = 4,
  parameter int NT  = 15,
  parameter int UPT = 2,
  parameter int IW  = 32,
  parameter int TW  = 6,
  parameter int PW  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NC-1:0]        req_valid,
  input logic [NC*IW-1:0]     req_instr,
  input logic [NC*TW-1:0]     req_task,
  input logic [NC*PW-1:0]     req_prio,
  input logic [NC-1:0]        req_ready,
  input logic [NC-1:0]        req_err,
  input logic [NT*UPT-1:0]    cop_valid,
  input logic [NT*UPT*IW-1:0] cop_instr,
  input logic [NT*UPT*TW-1:0] cop_task,
  input logic [NT*UPT-1:0]    cop_ready
);
  for (genvar u = 0; u < NT*UPT; u++) begin : g_u
    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cop_valid[u] |-> cop_ready[u]); // R8
    AST_ROUTE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      cop_valid[u] |-> (cop_instr[u*IW+IW-1 -: 4] == 4'(u/UPT + 1))); // R1
  end

  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_ONE_PER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cop_valid[t*UPT +: UPT])); // R8
  end

  for (genvar c = 0; c < NC; c++) begin : g_c
    AST_ERR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      req_err[c] |-> req_ready[c]); // R2
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[c] |-> req_valid[c]); // R6
  end

  AST_GRANT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ready & ~req_err) == $countones(cop_valid)); // R6
endmodule

bind cop_req_switch cfs_checker #(
  .NC(NC), .NT(NT), .UPT(UPT), .IW(IW), .TW(TW), .PW(PW)
) i_chk (.*);

// File: tb/test_cop_req_switch.sv
module test_cop_req_switch;
  localparam int PER = 10;
  localparam int NC  = 3;
  localparam int NT  = 3;
  localparam int UPT = 2;
  localparam int IW  = 8;
  localparam int TW  = 4;
  localparam int PW  = 2;
  localparam int NU  = NT*UPT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PER/2) clk = ~clk;

  logic [NC-1:0]     req_valid;
  logic [NC*IW-1:0]  req_instr;
  logic [NC*TW-1:0]  req_task;
  logic [NC*PW-1:0]  req_prio;
  logic [NC-1:0]     req_ready, req_err;
  logic [NU-1:0]     cop_valid;
  logic [NU*IW-1:0]  cop_instr;
  logic [NU*TW-1:0]  cop_task;
  logic [NU-1:0]     cop_ready;

  logic          v_i   [NC];
  logic [IW-1:0] ins_i [NC];
  logic [TW-1:0] tsk_i [NC];
  logic [PW-1:0] pr_i  [NC];

  always_comb
    for (int c = 0; c < NC; c++) begin
      req_valid[c]          = v_i[c];
      req_instr[c*IW +: IW] = ins_i[c];
      req_task[c*TW +: TW]  = tsk_i[c];
      req_prio[c*PW +: PW]  = pr_i[c];
    end

  cop_req_switch #(.NC(NC), .NT(NT), .UPT(UPT), .IW(IW), .TW(TW), .PW(PW)) i_cop_req_switch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
    .req_task(req_task), .req_prio(req_prio), .req_ready(req_ready), .req_err(req_err),
    .cop_valid(cop_valid), .cop_instr(cop_instr), .cop_task(cop_task), .cop_ready(cop_ready)
  );

  int total = 0;
  int bad   = 0;
  int mptr [NT];
  int nptr [NT];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(int c, bit v, int grp, int low, int tsk, int pr);
    v_i[c]   = v;
    ins_i[c] = IW'((grp << 4) | (low & 15));
    tsk_i[c] = TW'(tsk);
    pr_i[c]  = PW'(pr);
  endtask

  // Model step: compare outputs mid-cycle, then advance model pointers at the edge.
  task automatic step(string tag);
    logic [NU-1:0] e_cv;
    logic [NC-1:0] e_rr, e_err;
    logic [NU*IW-1:0] e_ins;
    logic [NU*TW-1:0] e_tsk;
    #(PER/2);
    e_cv = '0; e_rr = '0; e_err = '0; e_ins = '0; e_tsk = '0;
    for (int t = 0; t < NT; t++) begin
      int maxp, win, k;
      nptr[t] = mptr[t];
      maxp = -1; win = -1; k = -1;
      for (int c = 0; c < NC; c++)
        if (v_i[c] && int'(ins_i[c][7:4]) == t+1 && int'(pr_i[c]) > maxp) maxp = int'(pr_i[c]);
      for (int i = 1; i <= NC; i++) begin
        int j;
        j = (mptr[t] + i) % NC;
        if (win < 0 && v_i[j] && int'(ins_i[j][7:4]) == t+1 && int'(pr_i[j]) == maxp) win = j;
      end
      for (int kk = 0; kk < UPT; kk++)
        if (k < 0 && cop_ready[t*UPT+kk]) k = kk;
      if (rst_n && win >= 0 && k >= 0) begin
        e_cv[t*UPT+k] = 1'b1;
        e_rr[win] = 1'b1;
        e_ins[(t*UPT+k)*IW +: IW] = ins_i[win];
        e_tsk[(t*UPT+k)*TW +: TW] = tsk_i[win];
        nptr[t] = win;
      end
    end
    for (int c = 0; c < NC; c++)
      if (rst_n && v_i[c] && (ins_i[c][7:4] == 0 || int'(ins_i[c][7:4]) > NT)) begin
        e_err[c] = 1'b1; e_rr[c] = 1'b1;
      end
    chk({tag, " cop_valid"}, 64'(cop_valid), 64'(e_cv));
    chk({tag, " req_ready"}, 64'(req_ready), 64'(e_rr));
    chk({tag, " req_err"},   64'(req_err),   64'(e_err));
    for (int u = 0; u < NU; u++)
      if (e_cv[u]) begin
        chk({tag, " cop_instr"}, 64'(cop_instr[u*IW +: IW]), 64'(e_ins[u*IW +: IW]));
        chk({tag, " cop_task"},  64'(cop_task[u*TW +: TW]),  64'(e_tsk[u*TW +: TW]));
      end
    @(posedge clk);
    if (rst_n) for (int t = 0; t < NT; t++) mptr[t] = nptr[t];
    #1;
  endtask

  initial begin
    #(PER*200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) mptr[t] = NC-1;
    for (int c = 0; c < NC; c++) set_req(c, 1'b1, 1, c, c, 1);
    cop_ready = '1;
    // R9: reset holds all handshakes low
    step("R9 reset");
    step("R9 reset");
    rst_n = 1'b1;
    #1;

    // R4: equal priority rotation starting at core 0
    for (int n = 0; n < 6; n++) begin
      #(PER/2);
      chk("R4 rotation", 64'(req_ready), 64'(1 << (n % NC)));
      @(posedge clk); mptr[0] = n % NC; #1;
    end

    // R3: highest priority wins, task number rides along (R1)
    set_req(0, 1, 2, 5, 7, 1); set_req(1, 1, 2, 6, 8, 0); set_req(2, 1, 2, 9, 11, 3);
    #(PER/2);
    chk("R3 priority", 64'(req_ready), 64'b100);
    chk("R1 task", 64'(cop_task[2*TW +: TW]), 64'd11);
    chk("R1 instr", 64'(cop_instr[2*IW +: IW]), 64'h29);
    @(posedge clk); mptr[1] = 2; #1;

    // R7 and R6: type 0 units busy, type 1 still flows
    cop_ready = 6'b111100;
    set_req(0, 1, 1, 3, 1, 3); set_req(1, 1, 2, 4, 2, 0); set_req(2, 0, 0, 0, 0, 0);
    #(PER/2);
    chk("R7 nonblock", 64'(req_ready), 64'b010);
    chk("R6 lowest unit", 64'(cop_valid), 64'b000100);
    @(posedge clk); mptr[1] = 1; #1;

    // R5: no transfer, pointer of type 0 stays; R6 second unit chosen
    set_req(0, 1, 1, 0, 0, 1); set_req(1, 1, 1, 0, 1, 1); set_req(2, 1, 1, 0, 2, 1);
    cop_ready = 6'b000000;
    step("R5 hold");
    cop_ready = 6'b000010;
    #(PER/2);
    chk("R5 pointer kept", 64'(req_ready), 64'(1 << ((mptr[0]+1) % NC)));
    chk("R6 unit1", 64'(cop_valid), 64'b000010);
    @(posedge clk); mptr[0] = (mptr[0]+1) % NC; #1;

    // R2: group 0 and an out-of-range group are discarded with error
    set_req(0, 1, 0, 1, 0, 0); set_req(1, 1, 9, 1, 0, 0); set_req(2, 0, 0, 0, 0, 0);
    cop_ready = '1;
    #(PER/2);
    chk("R2 err", 64'(req_err), 64'b011);
    chk("R2 no forward", 64'(cop_valid), 64'd0);
    @(posedge clk); #1;

    // Sweep over all features, mostly legal groups, small priorities
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NC; c++)
        set_req(c, ($urandom % 4) != 0, (($urandom % 8) == 0) ? ($urandom % 16) : ($urandom % NT) + 1,
                $urandom % 16, $urandom % 16, $urandom % 4);
      cop_ready = NU'($urandom);
      step("R1 R3 R4 R5 R6 R8 sweep");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule